// File: doc/BRIEF.md
# Preloaded Modulo-N Rate Divider

This block divides the rate of its enabled clock cycles by a programmable factor N between 2 and 16. A 4-bit up-counter runs from a start value of 16 − N to its top value of 15. When it is at the top and enabled, it reloads the start value instead of wrapping to zero. The count therefore walks through exactly N states. A terminal-count flag marks the last of them, and the two low count bits are brought out as divided square-ish outputs.

The divisor is sampled continuously. A count that sits below the current start value is not a legal state. This can happen after a divisor change, or after an upset of the register. Such a count is repaired to the start value on the very next clock, whether or not counting is enabled. A synchronous reset also loads the start value, so the first enabled cycle after reset begins a full period. The terminal-count flag is gated by the count enable, so it can feed the enable of a following stage directly.

Top module: `modn_divider`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count is loaded with the start value 16 − N.
- R2: With `cnt_en` high and a legal count below 15, the count rises by exactly one on each clock.
- R3: With `cnt_en` high and the count at 15, the next count is the start value. The count repeats with a period of exactly N enabled cycles.
- R4: `tc` is high exactly when the count is 15 and `cnt_en` is high.
- R5: With `cnt_en` low and a legal count, the count holds its value and `tc` stays low.
- R6: A count below the start value is replaced by the start value on the next clock, whatever the level of `cnt_en`. A count at or above the start value is left alone.
- R7: A divisor of 16 gives a start value of 0, so the count runs freely through all 16 values.
- R8: A `divisor` of 0 or 1 acts as 2, and any `divisor` above 16 (5-bit code 17 to 31) acts as 16.
- R9: `tap_lo` equals count bit 0 and `tap_hi` equals count bit 1. At N = 3, `tap_lo` is low in one cycle of every three and `tap_hi` is high in two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads the start value |
| cnt_en | input | 1 | Count enable |
| divisor | input | 5 | Division factor N, unsigned |
| count | output | 4 | Current count |
| tc | output | 1 | Terminal count qualified by the enable |
| tap_lo | output | 1 | Divided output taken from count bit 0 |
| tap_hi | output | 1 | Divided output taken from count bit 1 |

## Verification
A count below the start value shows up on the `count` port as a value outside the N-value cycle. It must be gone one clock later. If repair were missing, the count would climb through extra states and the first `tc` would arrive late by that many cycles. A wrong reload value shifts the period, so a `tc` period other than N exposes it within one full cycle. A wrong enable qualifier makes `tc` appear while counting is stalled, which shows in the same cycle. The sweep therefore covers every divisor code, with full periods, stalls and forced illegal states.

// File: rtl/modn_pkg.sv
package modn_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_WRAP = 2'd2,
    ACT_LOAD = 2'd3
  } act_e;

endpackage

// File: rtl/modn_preload.sv
module modn_preload #(
  parameter int W = 4
) (
  input  logic [W:0]   divisor,
  output logic [W-1:0] preload
);
  localparam int MODV = 1 << W;

  function automatic int clamp_div(input int d);
    if (d < 2)    return 2;
    if (d > MODV) return MODV;
    return d;
  endfunction

  function automatic logic [W-1:0] start_of(input int d);
    int s;
    s = MODV - clamp_div(d);
    return s[W-1:0];
  endfunction

  assign preload = start_of(int'(divisor));

  always_comb begin
    assert_start_range_R8: assert (int'(preload) <= MODV - 2)
      else $error("start value leaves room for fewer than two states");
  end
endmodule

// File: rtl/modn_ctrl.sv
module modn_ctrl
  import modn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         rst,
  input  logic         cnt_en,
  input  logic [W-1:0] count,
  input  logic [W-1:0] preload,
  output act_e         act,
  output logic         bad_state,
  output logic         at_top
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  assign bad_state = (count < preload);
  assign at_top    = (count == TOP);

  always_comb begin
    if (rst || bad_state) act = ACT_LOAD;
    else if (!cnt_en)     act = ACT_HOLD;
    else if (at_top)      act = ACT_WRAP;
    else                  act = ACT_STEP;
  end
endmodule

// File: rtl/modn_count.sv
module modn_count
  import modn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  act_e         act,
  input  logic [W-1:0] preload,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    case (act)
      ACT_STEP: count <= count + 1'b1;
      ACT_WRAP: count <= preload;
      ACT_LOAD: count <= preload;
      default:  count <= count;
    endcase
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    act == ACT_STEP |=> count == W'($past(count) + 1'b1));
  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    act == ACT_WRAP |=> count == $past(preload));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    act == ACT_HOLD |=> $stable(count));
endmodule

// File: rtl/modn_divider.sv
module modn_divider
  import modn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic [W:0]   divisor,
  output logic [W-1:0] count,
  output logic         tc,
  output logic         tap_lo,
  output logic         tap_hi
);
  logic [W-1:0] preload;
  logic         bad_state;
  logic         at_top;
  act_e         act;

  modn_preload #(.W(W)) u_pre (
    .divisor (divisor),
    .preload (preload)
  );

  modn_ctrl #(.W(W)) u_ctrl (
    .rst       (rst),
    .cnt_en    (cnt_en),
    .count     (count),
    .preload   (preload),
    .act       (act),
    .bad_state (bad_state),
    .at_top    (at_top)
  );

  modn_count #(.W(W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .preload (preload),
    .count   (count)
  );

  assign tc     = at_top & cnt_en;
  assign tap_lo = count[0];
  assign tap_hi = count[1];

  assert_tc_reload_R4: assert property (@(posedge clk) disable iff (rst)
    tc |=> count == $past(preload));
  assert_repair_R6: assert property (@(posedge clk) disable iff (rst)
    bad_state |=> count == $past(preload));
  assert_idle_tc_R5: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |-> !tc);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> count == $past(preload) || rst);
endmodule

// File: tb/sim_modn_divider.sv
module sim_modn_divider;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic       cnt_en = 0;
  logic [4:0] divisor = 5'd3;
  logic [3:0] count;
  logic       tc, tap_lo, tap_hi;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  modn_divider u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .divisor(divisor),
    .count(count), .tc(tc), .tap_lo(tap_lo), .tap_hi(tap_hi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wrap_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int eff(input int d);
    return (d < 2) ? 2 : ((d > 16) ? 16 : d);
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        chk(0, "watchdog", cycles, 100000);
        wrap_up();
      end
    end
  end

  initial begin
    int lo_low, hi_high;
    #1;
    for (int d = 0; d < 32; d++) begin
      int n, s;
      n = eff(d);
      s = 16 - n;
      rst = 1; cnt_en = 0; divisor = 5'(d);
      step();
      rst = 0;
      chk(int'(count) == s, (d < 2 || d > 16) ? "R8 clamp" : "R1 reset", count, s);
      cnt_en = 1;
      lo_low = 0; hi_high = 0;
      for (int k = 0; k < 3 * n; k++) begin
        int e;
        e = s + (k % n);
        chk(tc == ((k % n) == n - 1), "R4 tc", tc, (k % n) == n - 1);
        chk(tap_lo == e[0] && tap_hi == e[1], "R9 taps", {tap_hi, tap_lo}, e & 3);
        if (!tap_lo) lo_low++;
        if (tap_hi) hi_high++;
        step();
        e = s + ((k + 1) % n);
        chk(int'(count) == e,
            (n == 16) ? "R7 free run" : (((k % n) == n - 1) ? "R3 reload" : "R2 step"),
            count, e);
      end
      if (d == 3) begin
        chk(lo_low == 3, "R9 tap_lo low count", lo_low, 3);
        chk(hi_high == 6, "R9 tap_hi high count", hi_high, 6);
      end
      cnt_en = 0;
      #1;
      for (int h = 0; h < 3; h++) begin
        chk(tc == 0, "R5 tc idle", tc, 0);
        step();
        chk(int'(count) == s, "R5 hold", count, s);
      end
    end

    // R6: illegal state repaired with enable low
    rst = 1; divisor = 5'd16; cnt_en = 0;
    step();
    rst = 0; cnt_en = 1;
    step();
    chk(count == 4'd1, "R7 setup", count, 1);
    cnt_en = 0; divisor = 5'd3;
    step();
    chk(count == 4'd13, "R6 repair idle", count, 13);
    step();
    chk(count == 4'd13, "R6 hold after repair", count, 13);

    // R6: illegal state repaired with enable high
    rst = 1; divisor = 5'd16;
    step();
    rst = 0; cnt_en = 1;
    step(); step();
    chk(count == 4'd2, "R2 setup", count, 2);
    divisor = 5'd5;
    step();
    chk(count == 4'd11, "R6 repair enabled", count, 11);
    step();
    chk(count == 4'd12, "R2 after repair", count, 12);

    // R6: legal state untouched after a divisor change
    rst = 1; divisor = 5'd16; cnt_en = 0;
    step();
    rst = 0; cnt_en = 1;
    for (int i = 0; i < 14; i++) step();
    chk(count == 4'd14, "R2 setup", count, 14);
    cnt_en = 0; divisor = 5'd3;
    step(); step();
    chk(count == 4'd14, "R6 legal kept", count, 14);
    cnt_en = 1;
    step();
    chk(count == 4'd15, "R2 resume", count, 15);
    step();
    chk(count == 4'd13, "R3 reload new N", count, 13);

    wrap_up();
  end
endmodule